// File: doc/BRIEF.md
# Serial Flash Page-Program Command Engine

This block is the device-side command logic of a serial NOR flash that accepts a page program over a single-bit SPI link (mode 0, most significant bit first). It decodes a small command set: write enable, status read and page program. For a page program it takes a 24-bit target address and collects the data bytes into a 256-byte staging page. The offset wraps inside that page. When chip select rises on a clean byte boundary, it runs a self-timed program cycle that writes the staged bytes into an external memory array through a simple write port.

The program is only carried out under three conditions. The write enable latch must already be set. At least one complete data byte must have been shifted in, and chip select must rise exactly after a byte's last bit. The target block must lie outside the region chosen by the 4-bit protect level. Programming is a bitwise AND into the array, so cells only move from 1 to 0. The length of the program cycle is a parameter counted in system clock cycles. SCK, CS# and DI are sampled on the system clock, which must run at least four times faster than SCK.

Top module: `page_program_engine`

## Requirements
- R1: After reset the status byte reads 00h when the protect level is 0, the serial output is low, and no array write occurs.
- R2: Opcode 06h sets the write enable latch. Opcode 05h returns the status byte {2'b00, protect[3:0], WEL, WIP} (WIP in bit 0, WEL in bit 1) MSB first, driven on SCK falling edges, and repeats it every 8 clocks while CS# stays low.
- R3: Opcode 02h issued while the write enable latch is clear has no effect: no array write, and WIP stays 0.
- R4: After 02h, the address comes as three bytes, MSB first. Data bytes fill consecutive locations from that address. Each location is written as old value AND new byte.
- R5: When the low address byte passes FFh, data continues at offset 00h of the same 256-byte page. No write ever leaves the addressed page.
- R6: When more than 256 data bytes are sent, only the last 256 are programmed.
- R7: Page locations that received no data byte are not written.
- R8: The program is discarded, and the write enable latch stays set, if CS# rises before any data byte or at a bit count other than a multiple of 8.
- R9: On an accepted program, WIP reads 1 for PROG_CYCLES clock cycles from the CS# rise and then 0. The write enable latch is clear from the start of the cycle.
- R10: With protect level L > 0, every address whose 64 KiB block index b satisfies (~b) >> (L-1) == 0 is protected (L=1: top block, L=8: upper half, L>=9: all). A program there is refused and the write enable latch stays set. L=0 protects nothing.
- R11: While WIP is 1, only opcode 05h is obeyed. 06h and 02h are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Chip select, active low |
| di | input | 1 | Serial data in, sampled on SCK rise |
| do_o | output | 1 | Serial data out, changed on SCK fall |
| bp_level | input | 4 | Block-protect level held by the device |
| arr_we | output | 1 | Array write strobe, one byte per cycle |
| arr_addr | output | 24 | Array byte address |
| arr_wdata | output | 8 | Array write data (old value AND staged byte) |
| arr_rdata | input | 8 | Array read data at arr_addr, combinational |

## Verification
Most internal faults show up at the array port within one program cycle. A wrong staging pointer or a wrong valid mask writes to the wrong offsets, or to too many or too few of them, and the byte contents and write count are compared once the cycle ends. A command-state fault shows as a wrong status byte on the next 05h read, a few dozen clocks after CS# rises. Examples are a latch left set, a WIP window of the wrong length, or a refused program that still consumes the latch. Faults in bit counting show up as programs that are executed when they should be discarded, or the reverse.

// File: rtl/spi_prog_pkg.sv
// Shared constants and types for the page-program engine.
package spi_prog_pkg;
    localparam int PAGE_BYTES = 256;
    localparam int IDX_W      = 8;

    localparam logic [7:0] CMD_SET_WE  = 8'h06;
    localparam logic [7:0] CMD_STATUS  = 8'h05;
    localparam logic [7:0] CMD_PAGE_WR = 8'h02;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_STAT,
        PH_IGN
    } phase_t;
endpackage

// File: rtl/spi_bit_port.sv
// Mode-0 serial front end. It samples SCK/CS#/DI on clk, assembles received
// bytes and shifts a status byte out on SCK falling edges.
// Assumes the inputs are synchronous to clk and that SCK runs at most clk/4.
module spi_bit_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       di,
    input  logic       tx_en,
    input  logic [7:0] tx_byte,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic [2:0] bit_cnt,
    output logic       cs_rise,
    output logic       do_o
);
    logic       sck_q, cs_q;
    logic [6:0] rx_sh;
    logic [6:0] tx_sh;
    logic [2:0] tx_cnt;
    logic       sck_rise, sck_fall;

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;

    // Previous-sample registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Shift in DI on SCK rise; pulse byte_vld after each eighth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= 3'd0;
            rx_sh     <= 7'd0;
            byte_vld  <= 1'b0;
            byte_data <= 8'd0;
        end else begin
            byte_vld <= 1'b0;
            if (cs_n) begin
                bit_cnt <= 3'd0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[5:0], di};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_vld  <= 1'b1;
                    byte_data <= {rx_sh, di};
                end
            end
        end
    end

    // Drive DO on SCK fall, reloading a live copy of tx_byte every 8 bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt <= 3'd0;
            tx_sh  <= 7'd0;
            do_o   <= 1'b0;
        end else if (cs_n) begin
            tx_cnt <= 3'd0;
            do_o   <= 1'b0;
        end else if (sck_fall && tx_en) begin
            tx_cnt <= tx_cnt + 3'd1;
            if (tx_cnt == 3'd0) begin
                do_o  <= tx_byte[7];
                tx_sh <= tx_byte[6:0];
            end else begin
                do_o  <= tx_sh[6];
                tx_sh <= {tx_sh[5:0], 1'b0};
            end
        end
    end

    p_bits_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (bit_cnt == 3'd0));
    p_do_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !do_o);
endmodule

// File: rtl/page_store.sv
// 256-byte staging page with a per-byte valid mask and a wrapping write pointer.
// The data storage has no reset; the valid mask alone marks which bytes hold data.
module page_store
    import spi_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [IDX_W-1:0] ld_off,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_vld
);
    logic [7:0]            mem [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;
    logic [IDX_W-1:0]      ptr;

    // Byte storage: a later byte at the same offset overwrites the earlier one.
    always_ff @(posedge clk) begin
        if (wr) mem[ptr] <= wdata;
    end

    // Valid mask and pointer: cleared per command, loaded with the start offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
        end else begin
            if (clr) vld <= '0;
            if (ld)  ptr <= ld_off;
            if (wr) begin
                vld[ptr] <= 1'b1;
                ptr      <= ptr + 1'b1;
            end
        end
    end

    assign rd_data = mem[rd_idx];
    assign rd_vld  = vld[rd_idx];

    p_wr_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (!clr && !ld));
endmodule

// File: rtl/block_guard.sv
// Protect decode: level L>0 covers the upper 2^(L-1) blocks of 64 KiB.
// Level 0 protects nothing; a level past the array size covers everything.
module block_guard #(
    parameter int BLK_W = 8
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [3:0]       level,
    output logic             hit
);
    // Protected when every block-index bit at or above L-1 is one.
    always_comb begin
        if (level == 4'd0) hit = 1'b0;
        else               hit = (((~blk) >> (level - 4'd1)) == '0);
    end
endmodule

// File: rtl/prog_sequencer.sv
// Self-timed program cycle. It stays busy for PROG_CYCLES clocks; during the
// first 256 clocks it walks the page offsets and writes each valid staged
// byte ANDed with the array's current content. Assumes PROG_CYCLES >= 256.
module prog_sequencer
    import spi_prog_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PROG_CYCLES = 300
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-IDX_W-1:0] page,
    input  logic [7:0]              buf_data,
    input  logic                    buf_vld,
    input  logic [7:0]              arr_rdata,
    output logic                    busy,
    output logic [IDX_W-1:0]        idx,
    output logic                    arr_we,
    output logic [ADDR_W-1:0]       arr_addr,
    output logic [7:0]              arr_wdata
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0]        cnt;
    logic [ADDR_W-IDX_W-1:0] page_q;
    logic                    in_window;

    // Cycle timer: the busy window is exactly PROG_CYCLES clocks long.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            cnt    <= '0;
            page_q <= page;
        end else if (busy) begin
            if (cnt == CNT_W'(PROG_CYCLES - 1)) busy <= 1'b0;
            else                                cnt  <= cnt + CNT_W'(1);
        end
    end

    assign in_window = busy && (cnt < CNT_W'(PAGE_BYTES));
    assign idx       = cnt[IDX_W-1:0];
    assign arr_we    = in_window && buf_vld;
    assign arr_addr  = {page_q, idx};
    assign arr_wdata = arr_rdata & buf_data;

    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/page_program_engine.sv
// Top of the page-program engine. It decodes write enable, status read and
// page program, captures the address, stages data and gates the program cycle
// on the write enable latch, byte-aligned CS# rise and block protection.
module page_program_engine
    import spi_prog_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PROG_CYCLES = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              di,
    output logic              do_o,
    input  logic [3:0]        bp_level,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata
);
    localparam int HI_W       = ADDR_W - IDX_W;
    localparam int BLK_W      = ADDR_W - 16;
    localparam int ADDR_BYTES = ADDR_W / 8;

    phase_t           phase;
    logic [HI_W-1:0]  addr_hi;
    logic [1:0]       addr_cnt;
    logic             got_data, wel, wip;
    logic             byte_vld, cs_rise, prot_hit, go;
    logic [7:0]       byte_data, status, buf_data;
    logic [2:0]       bit_cnt;
    logic [IDX_W-1:0] rd_idx;
    logic             buf_vld, buf_clr, buf_ld, buf_wr;

    assign status  = {2'b00, bp_level, wel, wip};
    assign buf_clr = byte_vld && (phase == PH_OPC) && (byte_data == CMD_PAGE_WR) && wel && !wip;
    assign buf_ld  = byte_vld && (phase == PH_ADDR) && (addr_cnt == 2'(ADDR_BYTES - 1));
    assign buf_wr  = byte_vld && (phase == PH_DATA);
    assign go      = cs_rise && (phase == PH_DATA) && got_data && (bit_cnt == 3'd0)
                     && !prot_hit && !wip;

    spi_bit_port u_port (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .di(di),
        .tx_en(phase == PH_STAT), .tx_byte(status),
        .byte_vld(byte_vld), .byte_data(byte_data), .bit_cnt(bit_cnt),
        .cs_rise(cs_rise), .do_o(do_o)
    );

    page_store u_page (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .ld(buf_ld),
        .ld_off(byte_data[IDX_W-1:0]), .wr(buf_wr), .wdata(byte_data),
        .rd_idx(rd_idx), .rd_data(buf_data), .rd_vld(buf_vld)
    );

    block_guard #(.BLK_W(BLK_W)) u_guard (
        .blk(addr_hi[HI_W-1:HI_W-BLK_W]), .level(bp_level), .hit(prot_hit)
    );

    prog_sequencer #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(go), .page(addr_hi),
        .buf_data(buf_data), .buf_vld(buf_vld), .arr_rdata(arr_rdata),
        .busy(wip), .idx(rd_idx), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata)
    );

    // Command decoder, address capture and write enable latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_OPC;
            addr_hi  <= '0;
            addr_cnt <= 2'd0;
            got_data <= 1'b0;
            wel      <= 1'b0;
        end else begin
            if (go) wel <= 1'b0;
            if (cs_n) begin
                phase    <= PH_OPC;
                addr_cnt <= 2'd0;
                got_data <= 1'b0;
            end else if (byte_vld) begin
                unique case (phase)
                    PH_OPC: begin
                        if (wip) begin
                            phase <= (byte_data == CMD_STATUS) ? PH_STAT : PH_IGN;
                        end else if (byte_data == CMD_SET_WE) begin
                            wel   <= 1'b1;
                            phase <= PH_IGN;
                        end else if (byte_data == CMD_STATUS) begin
                            phase <= PH_STAT;
                        end else if (byte_data == CMD_PAGE_WR && wel) begin
                            phase <= PH_ADDR;
                        end else begin
                            phase <= PH_IGN;
                        end
                    end
                    PH_ADDR: begin
                        addr_cnt <= addr_cnt + 2'd1;
                        if (addr_cnt == 2'(ADDR_BYTES - 1)) phase <= PH_DATA;
                        else addr_hi <= {addr_hi[HI_W-9:0], byte_data};
                    end
                    PH_DATA: got_data <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> !wel);
    p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_addr[ADDR_W-1:IDX_W] == addr_hi));
    p_unprotected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !prot_hit);
    p_busy_status_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && byte_vld && !cs_n && phase == PH_OPC) |=> (phase != PH_ADDR));
    p_wel_by_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(byte_vld));
endmodule

// File: tb/sim_page_program_engine.sv
`timescale 1ns/1ps
module sim_page_program_engine;
    localparam int PC = 600;
    localparam int H  = 4;

    typedef struct packed {
        logic [23:0] a;
        logic [9:0]  n;
        logic [3:0]  bp;
        logic        we;
        logic        go;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{24'h000010, 10'd4,   4'd0, 1'b1, 1'b1},
        '{24'h0000FE, 10'd5,   4'd0, 1'b1, 1'b1},
        '{24'h000105, 10'd300, 4'd0, 1'b1, 1'b1},
        '{24'h000200, 10'd3,   4'd0, 1'b0, 1'b0},
        '{24'hFF0000, 10'd2,   4'd1, 1'b1, 1'b0},
        '{24'hFE0000, 10'd2,   4'd1, 1'b1, 1'b1},
        '{24'h800300, 10'd1,   4'd8, 1'b1, 1'b0},
        '{24'h7F0300, 10'd1,   4'd8, 1'b1, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, di = 1'b0;
    logic [3:0]  bp = 4'd0;
    logic        do_o, arr_we, fill_req = 1'b0;
    logic [23:0] arr_addr;
    logic [7:0]  arr_wdata, arr_rdata, junk, st, st2;
    logic [7:0]  mem [1024];
    logic [7:0]  expv [256];
    int n_we = 0, checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    page_program_engine #(.ADDR_W(24), .PROG_CYCLES(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .di(di), .do_o(do_o),
        .bp_level(bp), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    assign arr_rdata = mem[arr_addr[9:0]];

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'hFF;
        end else if (arr_we) begin
            mem[arr_addr[9:0]] <= arr_wdata;
            n_we <= n_we + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill();
        fill_req = 1'b1; tick(1); fill_req = 1'b0; tick(1);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 7; b > 7 - n; b--) begin
            di = tx[b];
            tick(H);
            rx[b] = do_o;
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic sel();
        cs_n = 1'b0; tick(2);
    endtask

    task automatic desel();
        tick(3); cs_n = 1'b1; tick(4);
    endtask

    task automatic rd_status(output logic [7:0] s);
        sel(); xfer(8'h05, junk); xfer(8'h00, s); desel();
    endtask

    task automatic wren();
        sel(); xfer(8'h06, junk); desel();
    endtask

    task automatic hdr(input logic [23:0] a);
        xfer(8'h02, junk); xfer(a[23:16], junk); xfer(a[15:8], junk); xfer(a[7:0], junk);
    endtask

    function automatic logic [7:0] pat(input int v, input int i);
        return 8'(i * 37 + v * 11 + 5);
    endfunction

    function automatic string tag(input int k);
        case (k)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R3";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int w0, bad, first;
        tick(5);
        rst_n = 1'b1;
        fill();
        // R1: reset state
        chk("R1 do_o", int'(do_o), 0);
        chk("R1 writes", n_we, 0);
        rd_status(st);
        chk("R1 status", int'(st), 8'h00);

        // R2: write enable then status, repeated within one select
        wren();
        sel(); xfer(8'h05, junk); xfer(8'h00, st); xfer(8'h00, st2); desel();
        chk("R2 status", int'(st), 8'h02);
        chk("R2 repeat", int'(st2), 8'h02);

        // Vector table
        for (int k = 0; k < 8; k++) begin
            fill();
            bp = VEC[k].bp;
            if (VEC[k].we) wren();
            w0 = n_we;
            sel(); hdr(VEC[k].a);
            for (int i = 0; i < int'(VEC[k].n); i++) xfer(pat(k, i), junk);
            desel();
            rd_status(st);
            if (VEC[k].go) begin
                chk("R9 wip high, wel low", int'(st[1:0]), 1);
            end else begin
                chk({tag(k), " wip stays 0"}, int'(st[0]), 0);
            end
            tick(PC + 20);
            chk({tag(k), " write count"}, n_we - w0,
                VEC[k].go ? ((VEC[k].n > 256) ? 256 : int'(VEC[k].n)) : 0);
            for (int j = 0; j < 256; j++) expv[j] = 8'hFF;
            if (VEC[k].go)
                for (int i = 0; i < int'(VEC[k].n); i++)
                    expv[(int'(VEC[k].a[7:0]) + i) % 256] = pat(k, i);
            bad = 0; first = -1;
            for (int j = 0; j < 256; j++)
                if (mem[{VEC[k].a[9:8], 8'(j)}] != expv[j]) begin
                    bad++;
                    if (first < 0) first = j;
                end
            if (first < 0) chk({tag(k), " page content R7"}, 0, 0);
            else chk({tag(k), " page content R7"}, int'(mem[{VEC[k].a[9:8], 8'(first)}]),
                     int'(expv[first]));
            rd_status(st);
            chk({tag(k), " final status R9"}, int'(st),
                int'({2'b00, VEC[k].bp, VEC[k].we && !VEC[k].go, 1'b0}));
        end
        bp = 4'd0;

        // R4: bitwise AND into the array
        fill();
        wren(); sel(); hdr(24'h000020); xfer(8'hF0, junk); desel(); tick(PC + 20);
        wren(); sel(); hdr(24'h000020); xfer(8'h3C, junk); desel(); tick(PC + 20);
        chk("R4 and-program", int'(mem[10'h020]), 8'h30);

        // R8: CS# rises mid-byte
        wren(); w0 = n_we;
        sel(); hdr(24'h000040); xfer(8'h11, junk); bits(8'h22, 3, junk); desel();
        tick(PC + 20);
        chk("R8 mid-byte writes", n_we - w0, 0);
        rd_status(st);
        chk("R8 wel kept", int'(st), 8'h02);
        // R8: no data byte at all
        sel(); hdr(24'h000040); desel(); tick(PC + 20);
        chk("R8 no-data writes", n_we - w0, 0);
        chk("R8 byte untouched", int'(mem[10'h040]), 8'hFF);

        // R11: commands during the program cycle
        sel(); hdr(24'h000060); xfer(8'hAA, junk); desel();
        wren();
        sel(); hdr(24'h000070); xfer(8'h00, junk); desel();
        tick(PC + 20);
        rd_status(st);
        chk("R11 wren ignored", int'(st), 8'h00);
        chk("R11 second program ignored", int'(mem[10'h070]), 8'hFF);
        chk("R11 first program done", int'(mem[10'h060]), 8'hAA);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule